// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. It also produces pixel coordinates inside the visible area and a one-cycle pulse at the start of a chosen line. It runs on the pixel clock. Each axis is programmed with four cumulative boundaries: the last count of sync, the last count of the back porch, the last count of the active region and the last count of the whole period. The block derives every phase from these four points, so no per-phase lengths are stored.

The four timing words arrive on plain input ports and serve as shadow copies. The counters and strobes use only a separate active copy, which is loaded from the shadows on request. A request either loads the active copy on the following cycle or waits for the last pixel of the frame, so a mode change lands cleanly between frames. While the generator is disabled, any pending request is carried out at once and the counters stay at zero. Separate control bits set the active level of each strobe and pass through a pixel-clock edge selection.

Top module: `lcd_timing_gen`

## Requirements
- R1: After synchronous reset the active timing copy is all zero, both reload-pending flags are 0 and both counters are 0. With a control word of zero, hsync, vsync and de are 1, their inactive level.
- R2: The horizontal field of each timing word is bits [27:16] and the vertical field is bits [10:0]. hsync is active while the horizontal count is at or below the sync field. vsync is active while the vertical count is at or below the vertical sync field.
- R3: de is active only when the horizontal count is above the back-porch field and at or below the active field, and the vertical count meets the same test on its own fields.
- R4: While de is active, pix_x equals the horizontal count minus the back-porch field minus one, and pix_y is formed the same way from the vertical count. Both are 0 while de is inactive.
- R5: In the control word, bit 31 set makes hsync active high, bit 30 set makes vsync active high and bit 29 set makes de active high. A cleared bit makes that signal active low. While disabled (bit 0 clear), all three sit at their inactive level.
- R6: The horizontal count runs from 0 to the total field and then returns to 0, so a line lasts total+1 cycles. The vertical count steps once at each line end and returns to 0 after its total field.
- R7: line_irq is high for exactly the single cycle in which the horizontal count is 0 and the vertical count equals irq_line, and only while enabled.
- R8: A change on the timing ports has no effect on the outputs until a reload copies it into the active set.
- R9: A write with reload_req bit 1 sets pending flag 1. While enabled, the copy takes place at the clock edge that ends the last pixel of the frame, which clears the flag. The new timing governs the frame that starts at that edge.
- R10: A write with reload_req bit 0 sets pending flag 0. The copy takes place at the next clock edge, which clears the flag.
- R11: While bit 0 of the control word is clear, both counters are held at 0, and any pending flag is served and cleared at the next edge. When the generator is enabled again, output starts at horizontal and vertical count 0.
- R12: pclk_inv follows bit 28 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Enable (bit 0) and polarity/edge controls (bits 31..28) |
| sync_cfg | input | 32 | Shadow: sync end boundary, horizontal [27:16], vertical [10:0] |
| bporch_cfg | input | 32 | Shadow: back-porch end boundary, same layout |
| active_cfg | input | 32 | Shadow: active-region end boundary, same layout |
| total_cfg | input | 32 | Shadow: period end boundary, same layout |
| reload_wr | input | 1 | Write strobe for reload_req |
| reload_req | input | 2 | Bit 0: copy now; bit 1: copy at end of frame |
| irq_line | input | 11 | Line number on which line_irq fires |
| hsync | output | 1 | Horizontal sync, polarity per bit 31 |
| vsync | output | 1 | Vertical sync, polarity per bit 30 |
| de | output | 1 | Data enable, polarity per bit 29 |
| pclk_inv | output | 1 | Pixel clock edge select, copy of bit 28 |
| line_irq | output | 1 | One-cycle pulse at start of the programmed line |
| pix_x | output | 12 | Column inside the active area |
| pix_y | output | 11 | Row inside the active area |
| reload_pend | output | 2 | Pending reload flags |

## Verification
The assertions assume a programmed timing set whose boundaries rise on each axis (sync ≤ back porch ≤ active ≤ total) and whose horizontal total is nonzero, so each line lasts more than one cycle. The stimulus only programs two such sets, one with a 9-cycle line and 6-line frame and one with a 6-cycle line and 5-line frame. It drives every input on the falling edge, which keeps each write strobe stable for exactly one rising edge. Each timing scan starts from a disable/enable step, so the bench knows the count phase without looking inside the block.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int H_W = 12;
    localparam int V_W = 11;
    localparam int H_LSB = 16;
    localparam int V_LSB = 0;

    localparam int EN_BIT   = 0;
    localparam int PCLK_BIT = 28;
    localparam int DE_BIT   = 29;
    localparam int VS_BIT   = 30;
    localparam int HS_BIT   = 31;

    localparam int REQ_NOW = 0;
    localparam int REQ_VBL = 1;

    typedef struct packed {
        logic [H_W-1:0] hsw;
        logic [H_W-1:0] hbp;
        logic [H_W-1:0] hact;
        logic [H_W-1:0] htot;
        logic [V_W-1:0] vsw;
        logic [V_W-1:0] vbp;
        logic [V_W-1:0] vact;
        logic [V_W-1:0] vtot;
    } tmg_t;

    function automatic tmg_t unpack_tmg(input logic [31:0] s, input logic [31:0] b,
                                        input logic [31:0] a, input logic [31:0] t);
        tmg_t r;
        r.hsw  = s[H_LSB +: H_W];
        r.hbp  = b[H_LSB +: H_W];
        r.hact = a[H_LSB +: H_W];
        r.htot = t[H_LSB +: H_W];
        r.vsw  = s[V_LSB +: V_W];
        r.vbp  = b[V_LSB +: V_W];
        r.vact = a[V_LSB +: V_W];
        r.vtot = t[V_LSB +: V_W];
        return r;
    endfunction

endpackage

// File: rtl/lcdt_reload.sv
module lcdt_reload
    import lcdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       wr,
    input  logic [1:0] req,
    input  logic       frame_end,
    input  tmg_t       shadow,
    output tmg_t       active,
    output logic [1:0] pend
);

    logic [1:0] served;

    // Disabled: everything pending is served. Enabled: "now" at once, "vbl" at frame end.
    always_comb begin
        if (!en) begin
            served = pend;
        end else begin
            served[REQ_NOW] = pend[REQ_NOW];
            served[REQ_VBL] = pend[REQ_VBL] & frame_end;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            active <= '0;
        end else begin
            if (|served) begin
                active <= shadow;
            end
            pend <= (pend & ~served) | (wr ? req : 2'b00);
        end
    end

    AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr) |=> (pend == 2'b00)); // R11
    AST_NOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pend[REQ_NOW] && !(wr && req[REQ_NOW])) |=> !pend[REQ_NOW]); // R10
    AST_VBL_WAITS: assert property (@(posedge clk) disable iff (rst)
        (en && pend[REQ_VBL] && !frame_end) |=> pend[REQ_VBL]); // R9
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && (pend == 2'b00)) |=> $stable(active)); // R8

endmodule

// File: rtl/lcdt_counters.sv
module lcdt_counters
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  tmg_t           tmg,
    output logic [H_W-1:0] hcnt,
    output logic [V_W-1:0] vcnt,
    output logic           frame_end
);

    logic h_last;
    logic v_last;

    // ">=" keeps the wrap safe when a reload shrinks the period below the count.
    assign h_last    = (hcnt >= tmg.htot);
    assign v_last    = (vcnt >= tmg.vtot);
    assign frame_end = en & h_last & v_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hcnt == '0 && vcnt == '0)); // R11
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && hcnt >= tmg.htot) |=> (hcnt == '0)); // R6
    AST_V_STEADY: assert property (@(posedge clk) disable iff (rst)
        (en && hcnt < tmg.htot) |=> $stable(vcnt)); // R6

endmodule

// File: rtl/lcdt_signals.sv
module lcdt_signals
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [31:0]    ctrl,
    input  tmg_t           tmg,
    input  logic [H_W-1:0] hcnt,
    input  logic [V_W-1:0] vcnt,
    input  logic [V_W-1:0] irq_line,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pclk_inv,
    output logic           line_irq,
    output logic [H_W-1:0] pix_x,
    output logic [V_W-1:0] pix_y
);

    logic en;
    logic hs_on;
    logic vs_on;
    logic de_on;
    logic h_vis;
    logic v_vis;

    assign en    = ctrl[EN_BIT];
    assign hs_on = en && (hcnt <= tmg.hsw);
    assign vs_on = en && (vcnt <= tmg.vsw);
    assign h_vis = (hcnt > tmg.hbp) && (hcnt <= tmg.hact);
    assign v_vis = (vcnt > tmg.vbp) && (vcnt <= tmg.vact);
    assign de_on = en && h_vis && v_vis;

    // Polarity bit set: active high; clear: active low.
    assign hsync    = ctrl[HS_BIT] ? hs_on : ~hs_on;
    assign vsync    = ctrl[VS_BIT] ? vs_on : ~vs_on;
    assign de       = ctrl[DE_BIT] ? de_on : ~de_on;
    assign pclk_inv = ctrl[PCLK_BIT];

    assign pix_x = de_on ? (hcnt - tmg.hbp - 1'b1) : '0;
    assign pix_y = de_on ? (vcnt - tmg.vbp - 1'b1) : '0;

    assign line_irq = en && (hcnt == '0) && (vcnt == irq_line);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (line_irq && tmg.htot != '0) |=> !line_irq); // R7

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [31:0]    ctrl_word,
    input  logic [31:0]    sync_cfg,
    input  logic [31:0]    bporch_cfg,
    input  logic [31:0]    active_cfg,
    input  logic [31:0]    total_cfg,
    input  logic           reload_wr,
    input  logic [1:0]     reload_req,
    input  logic [V_W-1:0] irq_line,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pclk_inv,
    output logic           line_irq,
    output logic [H_W-1:0] pix_x,
    output logic [V_W-1:0] pix_y,
    output logic [1:0]     reload_pend
);

    tmg_t           shadow;
    tmg_t           active;
    logic [H_W-1:0] hcnt;
    logic [V_W-1:0] vcnt;
    logic           frame_end;

    assign shadow = unpack_tmg(sync_cfg, bporch_cfg, active_cfg, total_cfg);

    lcdt_reload u_reload (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_word[EN_BIT]),
        .wr        (reload_wr),
        .req       (reload_req),
        .frame_end (frame_end),
        .shadow    (shadow),
        .active    (active),
        .pend      (reload_pend)
    );

    lcdt_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_word[EN_BIT]),
        .tmg       (active),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .frame_end (frame_end)
    );

    lcdt_signals u_sig (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_word),
        .tmg      (active),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .irq_line (irq_line),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de),
        .pclk_inv (pclk_inv),
        .line_irq (line_irq),
        .pix_x    (pix_x),
        .pix_y    (pix_y)
    );

endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ctrl_word;
    logic [31:0] sync_cfg, bporch_cfg, active_cfg, total_cfg;
    logic        reload_wr;
    logic [1:0]  reload_req;
    logic [10:0] irq_line;
    logic        hsync, vsync, de, pclk_inv, line_irq;
    logic [11:0] pix_x;
    logic [10:0] pix_y;
    logic [1:0]  reload_pend;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int hsw, hbp, hact, htot;
        int vsw, vbp, vact, vtot;
    } cfg_t;

    cfg_t cfg_a = '{1, 2, 6, 8, 0, 1, 4, 5};
    cfg_t cfg_b = '{0, 1, 4, 5, 0, 1, 3, 4};

    lcd_timing_gen u_dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .sync_cfg(sync_cfg), .bporch_cfg(bporch_cfg),
        .active_cfg(active_cfg), .total_cfg(total_cfg),
        .reload_wr(reload_wr), .reload_req(reload_req), .irq_line(irq_line),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
        .line_irq(line_irq), .pix_x(pix_x), .pix_y(pix_y),
        .reload_pend(reload_pend)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word(input int h, input int v);
        return {4'b0, h[11:0], 5'b0, v[10:0]};
    endfunction

    task automatic load_shadow(input cfg_t c);
        sync_cfg   = word(c.hsw,  c.vsw);
        bporch_cfg = word(c.hbp,  c.vbp);
        active_cfg = word(c.hact, c.vact);
        total_cfg  = word(c.htot, c.vtot);
    endtask

    // Called right after a falling edge; write strobe is seen by the next rising edge.
    task automatic pulse_req(input logic [1:0] bits);
        reload_wr  = 1'b1;
        reload_req = bits;
        @(negedge clk);
        reload_wr  = 1'b0;
        reload_req = 2'b00;
    endtask

    // Disable for one edge, then enable; ends right after the falling edge where count is 0.
    task automatic restart(input logic [31:0] ctrl);
        @(negedge clk);
        ctrl_word = ctrl & ~32'h1;
        @(negedge clk);
        ctrl_word = ctrl;
    endtask

    task automatic cmp_cycle(input cfg_t c, input int k, input logic [31:0] ctrl);
        int  h, v;
        bit  hs_a, vs_a, de_a;
        int  ex, ey;
        h    = k % (c.htot + 1);
        v    = (k / (c.htot + 1)) % (c.vtot + 1);
        hs_a = (h <= c.hsw);
        vs_a = (v <= c.vsw);
        de_a = (h > c.hbp) && (h <= c.hact) && (v > c.vbp) && (v <= c.vact);
        ex   = de_a ? h - c.hbp - 1 : 0;
        ey   = de_a ? v - c.vbp - 1 : 0;
        #1;
        chk(hsync == (ctrl[31] ? hs_a : !hs_a), "R2 R5 hsync", hsync, ctrl[31] ? hs_a : !hs_a);
        chk(vsync == (ctrl[30] ? vs_a : !vs_a), "R2 R5 vsync", vsync, ctrl[30] ? vs_a : !vs_a);
        chk(de == (ctrl[29] ? de_a : !de_a), "R3 R5 de", de, ctrl[29] ? de_a : !de_a);
        chk(pix_x == ex, "R4 pix_x", pix_x, ex);
        chk(pix_y == ey, "R4 pix_y", pix_y, ey);
        chk(line_irq == (h == 0 && v == irq_line), "R7 R6 line_irq", line_irq,
            (h == 0 && v == irq_line));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        ctrl_word = 32'h0;
        reload_wr = 1'b0;
        reload_req = 2'b00;
        irq_line = 11'd5;
        load_shadow(cfg_a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(hsync == 1'b1, "R1 hsync idle", hsync, 1);
        chk(vsync == 1'b1, "R1 vsync idle", vsync, 1);
        chk(de == 1'b1, "R1 de idle", de, 1);
        chk(reload_pend == 2'b00, "R1 pending", reload_pend, 0);
        chk(pix_x == 0 && pix_y == 0, "R1 coords", pix_x, 0);
        chk(pclk_inv == 1'b0, "R12 pclk_inv low", pclk_inv, 0);
    endtask

    task automatic t_load_disabled;
        ctrl_word = 32'hE000_0000;
        #1;
        chk(hsync == 0 && vsync == 0 && de == 0, "R5 idle level high pol", {hsync, vsync, de}, 0);
        @(negedge clk);
        pulse_req(2'b01);
        #1;
        chk(reload_pend == 2'b01, "R10 flag set", reload_pend, 1);
        @(negedge clk);
        #1;
        chk(reload_pend == 2'b00, "R11 served while disabled", reload_pend, 0);
        @(negedge clk);
        pulse_req(2'b10);
        @(negedge clk);
        #1;
        chk(reload_pend == 2'b00, "R11 vbl served while disabled", reload_pend, 0);
        chk(line_irq == 1'b0, "R7 no irq disabled", line_irq, 0);
    endtask

    task automatic t_frame(input logic [31:0] ctrl);
        restart(ctrl);
        for (int k = 0; k < 2 * 54; k++) begin
            cmp_cycle(cfg_a, k, ctrl);
            @(negedge clk);
        end
        #1;
        chk(pclk_inv == ctrl[28], "R12 pclk_inv", pclk_inv, ctrl[28]);
    endtask

    task automatic t_vbl_reload;
        logic [31:0] ctrl = 32'hE000_0001;
        restart(ctrl);
        for (int k = 0; k < 54 + 30; k++) begin
            if (k < 54) cmp_cycle(cfg_a, k, ctrl);
            else        cmp_cycle(cfg_b, k - 54, ctrl);
            if (k == 50) chk(reload_pend == 2'b10, "R9 waits for frame end", reload_pend, 2);
            if (k == 54) chk(reload_pend == 2'b00, "R9 cleared at frame end", reload_pend, 0);
            if (k == 2) load_shadow(cfg_b);   // R8: no effect until reload
            if (k == 53) irq_line = 11'd4;
            if (k == 10) pulse_req(2'b10);
            else @(negedge clk);
        end
    endtask

    task automatic t_now_reload;
        logic [31:0] ctrl = 32'h0000_0001;
        load_shadow(cfg_a);
        irq_line = 11'd5;
        @(negedge clk);
        pulse_req(2'b01);
        @(negedge clk);
        restart(ctrl);
        for (int k = 0; k < 8; k++) begin
            if (k == 6) chk(reload_pend == 2'b01, "R10 flag set", reload_pend, 1);
            if (k == 7) chk(reload_pend == 2'b00, "R10 flag cleared next edge", reload_pend, 0);
            if (k == 1) load_shadow(cfg_b);
            if (k == 5) pulse_req(2'b01);
            else @(negedge clk);
        end
        load_shadow(cfg_a);  // R8: not copied, no request
        irq_line = 11'd4;
        restart(ctrl);
        for (int k = 0; k < 30; k++) begin
            cmp_cycle(cfg_b, k, ctrl);
            @(negedge clk);
        end
    endtask

    task automatic t_disable;
        irq_line = 11'd0;
        @(negedge clk);
        ctrl_word = 32'h0;
        @(negedge clk);
        #1;
        chk(line_irq == 1'b0, "R11 R7 no irq while held", line_irq, 0);
        chk(hsync == 1 && vsync == 1 && de == 1, "R11 R5 inactive when off", {hsync, vsync, de}, 7);
    endtask

    initial begin
        t_reset();
        t_load_disabled();
        t_frame(32'hE000_0001);
        t_frame(32'h1000_0001);
        t_vbl_reload();
        t_now_reload();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule